// File: doc/BRIEF.md
# DRAM Read Command Spacing Tracker

This block sits beside the command scheduler of one DRAM channel. It decides, on every DRAM clock, whether a READ may be issued to a candidate rank and bank. It watches the ACTIVATE, WRITE and READ commands that the scheduler has already issued and keeps down-counters from them. Each rank and bank has its own activate timer. Each rank has separate timers for its last write and its last read. A request is marked eligible only when every minimum gap that applies to it has run out.

The five minimum gaps come from one 24-bit configuration word that software can write and read back. The scheduler presents a candidate rank and bank on the request inputs. The eligibility output is combinational on that candidate and on the current timer state. A command on the command port is counted from the edge at which it is issued. It therefore never constrains a request in its own issue cycle.

Top module: `rd_gap_tracker`

## Requirements
- R1: After reset the configuration word reads 0 and every rank and bank is eligible for a READ.
- R2: A configuration write is stored at the clock edge. From the next cycle cfg_rdata returns bits 20:0 of the written value, and bits 23:21 always read 0.
- R3: Bits 20:17 hold the ACTIVATE-to-READ gap G. After an ACTIVATE to rank k, bank j, issued in cycle t, a READ to that same rank and bank is eligible only in cycles t+d with d >= G. Other banks of the same rank are not affected.
- R4: Bits 16:12 hold the WRITE-to-READ gap for the same rank. A WRITE to rank k in cycle t blocks READs to rank k until cycle t+G.
- R5: Bits 11:8 hold the WRITE-to-READ gap for a different rank. A WRITE to rank k in cycle t blocks READs to every other rank until cycle t+G.
- R6: Bits 7:4 hold the READ-to-READ gap for the same rank. A READ to rank k in cycle t blocks READs to rank k until cycle t+G.
- R7: Bits 3:0 hold the READ-to-READ gap for different ranks. A READ to rank k in cycle t blocks READs to every other rank until cycle t+G.
- R8: rd_ok is the AND of all applicable gaps. A gap of 0 or 1 adds no constraint beyond the cycle after the issue cycle.
- R9: A command uses the gap values stored at the moment it is issued. A configuration write in the same cycle as a command, or later, does not change that command's spacing.
- R10: Command encoding on cmd_type is 01 ACTIVATE, 10 WRITE, 11 READ, and 00 none. When cmd_valid is low, or cmd_type is 00, no timer is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration write value |
| cfg_rdata | output | 24 | Configuration read-back |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 01 ACTIVATE, 10 WRITE, 11 READ, 00 none |
| cmd_rank | input | RW | Rank of the issued command |
| cmd_bank | input | BW | Bank of the issued command |
| req_rank | input | RW | Rank of the candidate READ |
| req_bank | input | BW | Bank of the candidate READ |
| rd_ok | output | 1 | Candidate READ satisfies all minimum gaps |

## Verification
The bench builds the block with the default 2 ranks and 8 banks. With these values it can sweep the request inputs over all 16 rank and bank pairs inside every cycle. This covers each same-rank and cross-rank relation, and both sides of every gap boundary, against a model that keeps issue times. The configurations include all zeros, all ones, mixed values and random words, some of them written in the same cycle as a command.

// File: rtl/rd_gap_tracker.sv
module rd_gap_tracker #(
  parameter int RANKS = 2,
  parameter int BANKS = 8,
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [23:0]   cfg_wdata,
  output logic [23:0]   cfg_rdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_type,
  input  logic [RW-1:0] cmd_rank,
  input  logic [BW-1:0] cmd_bank,
  input  logic [RW-1:0] req_rank,
  input  logic [BW-1:0] req_bank,
  output logic          rd_ok
);
  localparam int CW = 5;

  logic [20:0]   cfg_q;
  logic [CW-1:0] act_cnt [RANKS][BANKS];
  logic [CW-1:0] wrs_cnt [RANKS];
  logic [CW-1:0] wrd_cnt [RANKS];
  logic [CW-1:0] rds_cnt [RANKS];
  logic [CW-1:0] rdd_cnt [RANKS];

  assign cfg_rdata = {3'b000, cfg_q};

  wire [CW-1:0] g_act = CW'(cfg_q[20:17]);
  wire [CW-1:0] g_wrs = CW'(cfg_q[16:12]);
  wire [CW-1:0] g_wrd = CW'(cfg_q[11:8]);
  wire [CW-1:0] g_rds = CW'(cfg_q[7:4]);
  wire [CW-1:0] g_rdd = CW'(cfg_q[3:0]);

  wire is_act = cmd_valid && (cmd_type == 2'b01);
  wire is_wr  = cmd_valid && (cmd_type == 2'b10);
  wire is_rd  = cmd_valid && (cmd_type == 2'b11);

  function automatic logic [CW-1:0] arm(input logic [CW-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

  function automatic logic [CW-1:0] drain(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      for (int r = 0; r < RANKS; r++) begin
        wrs_cnt[r] <= '0;
        wrd_cnt[r] <= '0;
        rds_cnt[r] <= '0;
        rdd_cnt[r] <= '0;
        for (int b = 0; b < BANKS; b++) act_cnt[r][b] <= '0;
      end
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[20:0];
      for (int r = 0; r < RANKS; r++) begin
        if (is_wr && cmd_rank == RW'(r)) begin
          wrs_cnt[r] <= arm(g_wrs);
          wrd_cnt[r] <= arm(g_wrd);
        end else begin
          wrs_cnt[r] <= drain(wrs_cnt[r]);
          wrd_cnt[r] <= drain(wrd_cnt[r]);
        end
        if (is_rd && cmd_rank == RW'(r)) begin
          rds_cnt[r] <= arm(g_rds);
          rdd_cnt[r] <= arm(g_rdd);
        end else begin
          rds_cnt[r] <= drain(rds_cnt[r]);
          rdd_cnt[r] <= drain(rdd_cnt[r]);
        end
        for (int b = 0; b < BANKS; b++) begin
          if (is_act && cmd_rank == RW'(r) && cmd_bank == BW'(b))
            act_cnt[r][b] <= arm(g_act);
          else
            act_cnt[r][b] <= drain(act_cnt[r][b]);
        end
      end
    end
  end

  always_comb begin
    rd_ok = (act_cnt[req_rank][req_bank] == '0);
    for (int r = 0; r < RANKS; r++) begin
      if (req_rank == RW'(r))
        rd_ok = rd_ok && (wrs_cnt[r] == '0) && (rds_cnt[r] == '0);
      else
        rd_ok = rd_ok && (wrd_cnt[r] == '0) && (rdd_cnt[r] == '0);
    end
  end
endmodule

module rd_gap_tracker_chk #(
  parameter int RW = 1,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [23:0]   cfg_wdata,
  input logic [23:0]   cfg_rdata,
  input logic          cmd_valid,
  input logic [1:0]    cmd_type,
  input logic [RW-1:0] cmd_rank,
  input logic [BW-1:0] cmd_bank,
  input logic [RW-1:0] req_rank,
  input logic [BW-1:0] req_bank,
  input logic          rd_ok
);
  a_r1_reset_cfg: assert property (@(posedge clk) !rst_n |=> cfg_rdata == 24'h0);

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {3'b000, $past(cfg_wdata[20:0])});

  a_r3_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b01 && cfg_rdata[20:17] > 4'd1) |=>
    (req_rank != $past(cmd_rank) || req_bank != $past(cmd_bank) || !rd_ok));

  a_r4_wr_same: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b10 && cfg_rdata[16:12] > 5'd1) |=>
    (req_rank != $past(cmd_rank) || !rd_ok));

  a_r5_wr_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b10 && cfg_rdata[11:8] > 4'd1) |=>
    (req_rank == $past(cmd_rank) || !rd_ok));

  a_r6_rd_same: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b11 && cfg_rdata[7:4] > 4'd1) |=>
    (req_rank != $past(cmd_rank) || !rd_ok));

  a_r7_rd_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b11 && cfg_rdata[3:0] > 4'd1) |=>
    (req_rank == $past(cmd_rank) || !rd_ok));
endmodule

bind rd_gap_tracker rd_gap_tracker_chk #(.RW(RW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
  .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .req_rank(req_rank),
  .req_bank(req_bank), .rd_ok(rd_ok)
);

// File: tb/rd_gap_tracker_bench.sv
`timescale 1ns/1ps
module rd_gap_tracker_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_type = '0;
  logic [0:0]  cmd_rank = '0;
  logic [2:0]  cmd_bank = '0;
  logic [0:0]  req_rank = '0;
  logic [2:0]  req_bank = '0;
  logic        rd_ok;

  rd_gap_tracker #(.RANKS(2), .BANKS(8)) u_rd_gap_tracker (.*);

  always #4 clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0;
  logic [23:0] m_cfg = '0;
  int act_t[2][8], act_g[2][8];
  int wr_t[2], wr_gs[2], wr_gd[2], rd_t[2], rd_gs[2], rd_gd[2];
  string phase_tag = "";

  function automatic bit ref_ok(int q, int b, output string tag);
    bit ok = 1;
    tag = "R8";
    if (cyc - act_t[q][b] < act_g[q][b]) begin ok = 0; tag = "R3"; end
    if (cyc - wr_t[q] < wr_gs[q]) begin ok = 0; tag = "R4"; end
    if (cyc - rd_t[q] < rd_gs[q]) begin ok = 0; tag = "R6"; end
    for (int r = 0; r < 2; r++) if (r != q) begin
      if (cyc - wr_t[r] < wr_gd[r]) begin ok = 0; tag = "R5"; end
      if (cyc - rd_t[r] < rd_gd[r]) begin ok = 0; tag = "R7"; end
    end
    if (phase_tag != "") tag = phase_tag;
    return ok;
  endfunction

  task automatic step(input bit v, input logic [1:0] ty, input int rk, input int bk,
                      input bit we, input logic [23:0] wd);
    string tag;
    bit exp;
    @(negedge clk);
    vectors++;
    if (cfg_rdata !== m_cfg) begin
      errors++;
      $display("FAIL R2: cfg_rdata=%h expected %h", cfg_rdata, m_cfg);
    end
    for (int q = 0; q < 2; q++)
      for (int b = 0; b < 8; b++) begin
        req_rank = q[0:0];
        req_bank = b[2:0];
        #0.2;
        exp = ref_ok(q, b, tag);
        vectors++;
        if (rd_ok !== exp) begin
          errors++;
          $display("FAIL %s: cyc=%0d rank=%0d bank=%0d rd_ok=%0b expected %0b",
                   tag, cyc, q, b, rd_ok, exp);
        end
      end
    cmd_valid = v; cmd_type = ty; cmd_rank = rk[0:0]; cmd_bank = bk[2:0];
    cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    #0.1;
    if (v) case (ty)
      2'b01: begin act_t[rk][bk] = cyc; act_g[rk][bk] = int'(m_cfg[20:17]); end
      2'b10: begin wr_t[rk] = cyc; wr_gs[rk] = int'(m_cfg[16:12]); wr_gd[rk] = int'(m_cfg[11:8]); end
      2'b11: begin rd_t[rk] = cyc; rd_gs[rk] = int'(m_cfg[7:4]); rd_gd[rk] = int'(m_cfg[3:0]); end
      default: ;
    endcase
    if (we) m_cfg = wd & 24'h1FFFFF;
    cyc++;
  endtask

  task automatic rand_run(input int n, input bit cfg_churn);
    for (int i = 0; i < n; i++) begin
      bit we = cfg_churn && ($urandom % 16 == 0);
      step($urandom % 8 != 0, 2'($urandom), int'($urandom % 2), int'($urandom % 8),
           we, 24'($urandom));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 0, '0);
  endtask

  initial begin
    #(8.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, cycles=%0d expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 2; r++) begin
      wr_t[r] = -100; rd_t[r] = -100;
      wr_gs[r] = 0; wr_gd[r] = 0; rd_gs[r] = 0; rd_gd[r] = 0;
      for (int b = 0; b < 8; b++) begin act_t[r][b] = -100; act_g[r][b] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    phase_tag = "R1";
    idle(1);
    phase_tag = "";

    step(0, 2'b00, 0, 0, 1, 24'hFFFFFF);
    idle(1);
    rand_run(300, 0);

    step(0, 2'b00, 0, 0, 1, {3'b000, 4'd0, 5'd0, 4'd0, 4'd0, 4'd0});
    idle(1);
    rand_run(200, 0);
    step(0, 2'b00, 0, 0, 1, {3'b000, 4'd1, 5'd1, 4'd1, 4'd1, 4'd1});
    rand_run(200, 0);

    step(0, 2'b00, 0, 0, 1, {3'b111, 4'd6, 5'd0, 4'd0, 4'd0, 4'd0});
    phase_tag = "R9";
    step(1, 2'b01, 1, 5, 1, {3'b000, 4'd2, 5'd0, 4'd0, 4'd0, 4'd0});
    idle(8);
    step(1, 2'b01, 0, 2, 0, '0);
    idle(4);
    phase_tag = "";

    step(0, 2'b00, 0, 0, 1, {3'b000, 4'd9, 5'd20, 4'd7, 4'd5, 4'd3});
    phase_tag = "R10";
    for (int i = 0; i < 12; i++) step(0, 2'(i % 4), i % 2, i % 8, 0, '0);
    for (int i = 0; i < 6; i++) step(1, 2'b00, i % 2, i % 8, 0, '0);
    phase_tag = "";

    step(1, 2'b10, 0, 0, 0, '0); idle(22);
    step(1, 2'b11, 1, 0, 0, '0); idle(8);
    step(1, 2'b01, 0, 3, 0, '0); idle(10);
    rand_run(400, 0);

    step(0, 2'b00, 0, 0, 1, {3'b000, 4'd3, 5'd7, 4'd2, 4'd4, 4'd1});
    rand_run(400, 0);
    step(0, 2'b00, 0, 0, 1, {3'b000, 4'd2, 5'd31, 4'd15, 4'd2, 4'd6});
    rand_run(400, 0);

    for (int k = 0; k < 4; k++) begin
      step(0, 2'b00, 0, 0, 1, 24'($urandom));
      rand_run(300, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule